// File: doc/BRIEF.md
# Horizontal Sync Pulse Generator

This block produces the horizontal sync pulse of a CRT-style raster timing chain. A free-running horizontal character counter and a character-clock enable come in from the surrounding timing logic. On each enabled character clock the block compares the counter with a programmed start position and with a 5-bit end position. It then passes the resulting pulse through a short programmable delay line, which makes up for pixel pipeline latency elsewhere.

Two start/end register pairs are held in a small indexed register file. A mode-select input picks which pair drives the comparators. The end register also carries the delay setting and the sixth bit of the horizontal blank-end value. That bit is exported for a companion blanking block. Software computes the end field as the start value plus the wanted width, truncated to five bits. The end comparator therefore looks only at the low five counter bits, and pulse widths of 1 to 32 character clocks come out correctly across the 5-bit wrap.

Top module: `hsync_gen`

## Requirements
- R1: A synchronous reset clears hsync, blank_end_b5 and all four registers, so every implemented index reads 00h after reset.
- R2: Index 04h holds the primary start value and 05h the primary end register; 14h and 15h hold the alternate pair. End register layout: bits 4:0 end field, bits 6:5 delay, bit 7 blank-end bit 5. A write of reg_wdata to an implemented index while reg_we is high reads back unchanged on reg_rdata (combinational read of reg_idx).
- R3: A read of any other index returns 00h, and a write to it changes none of the four registers.
- R4: On an enabled cycle where hcount equals the selected start value, the undelayed sync becomes high after that clock edge.
- R5: On an enabled cycle where hcount[4:0] equals the selected end field and hcount differs from the start value, the undelayed sync becomes low after that edge. With end = (start + N) mod 32, the pulse lasts N enabled cycles for every N from 1 to 32.
- R6: When the start and end comparisons match on the same enabled cycle, start wins: sync is set and the pulse ends at the next low-5-bit match, 32 enabled cycles later.
- R7: hsync is the undelayed sync delayed by 0, 1, 2 or 3 enabled character clocks, chosen by the delay field of the selected end register. With delay d, the first high sample appears with the counter at start+1+d.
- R8: On cycles with cclk_en low, neither the comparators nor the delay line advance, whatever hcount does.
- R9: alt_sel low selects the primary pair and alt_sel high selects the alternate pair. The selection covers start, end field, delay and blank-end bit.
- R10: blank_end_b5 equals bit 7 of the selected end register.
- R11: A register write made in the same cycle as an enabled comparison does not affect that comparison. It takes effect from the next enabled cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cclk_en | input | 1 | Character-clock enable |
| hcount | input | 8 | Horizontal character counter |
| alt_sel | input | 1 | 0 = primary register pair, 1 = alternate pair |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 8 | Register index for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_idx |
| hsync | output | 1 | Delayed horizontal sync |
| blank_end_b5 | output | 1 | Blank-end bit 5 from the selected end register |

## Verification
The undelayed sync is registered once, so a start or end match seen at one enabled edge shows on hsync right after that edge when the delay is zero. Each delay step adds one further enabled edge, and cycles with the enable low add nothing. Register reads and blank_end_b5 are combinational from registers that update at the write edge, so they are due right after that edge. The bench drives each cycle's inputs at the falling edge and advances its own model at the rising edge. It compares every output at the following falling edge, so every expected value is sampled exactly one edge after the stimulus that caused it.

// File: rtl/hsync_pkg.sv
package hsync_pkg;

    localparam int CNT_W  = 8;
    localparam int DATA_W = 8;
    localparam int IDX_W  = 8;
    localparam int END_W  = 5;
    localparam int DLY_W  = 2;

    localparam logic [IDX_W-1:0] IDX_START_PRI = 8'h04;
    localparam logic [IDX_W-1:0] IDX_END_PRI   = 8'h05;
    localparam logic [IDX_W-1:0] IDX_START_ALT = 8'h14;
    localparam logic [IDX_W-1:0] IDX_END_ALT   = 8'h15;

    typedef struct packed {
        logic             blank5;
        logic [DLY_W-1:0] dly;
        logic [END_W-1:0] stop;
    } end_reg_t;

    typedef struct packed {
        logic [CNT_W-1:0] start;
        end_reg_t         fin;
    } pair_t;

    typedef enum logic {
        PAIR_PRI = 1'b0,
        PAIR_ALT = 1'b1
    } pair_sel_e;

    function automatic logic low_match(input logic [CNT_W-1:0] cnt,
                                       input logic [END_W-1:0] stop);
        return cnt[END_W-1:0] == stop;
    endfunction

endpackage

// File: rtl/hsync_regfile.sv
module hsync_regfile
    import hsync_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              alt_sel,
    output logic [DATA_W-1:0] rdata,
    output pair_t             sel_pair
);

    pair_t     pri_q;
    pair_t     alt_q;
    pair_sel_e which;

    always_ff @(posedge clk) begin
        if (rst) begin
            pri_q <= '0;
            alt_q <= '0;
        end else if (we) begin
            case (idx)
                IDX_START_PRI: pri_q.start <= wdata;
                IDX_END_PRI:   pri_q.fin   <= end_reg_t'(wdata);
                IDX_START_ALT: alt_q.start <= wdata;
                IDX_END_ALT:   alt_q.fin   <= end_reg_t'(wdata);
                default: ;
            endcase
        end
    end

    always_comb begin
        case (idx)
            IDX_START_PRI: rdata = pri_q.start;
            IDX_END_PRI:   rdata = DATA_W'(pri_q.fin);
            IDX_START_ALT: rdata = alt_q.start;
            IDX_END_ALT:   rdata = DATA_W'(alt_q.fin);
            default:       rdata = '0;
        endcase
    end

    assign which    = pair_sel_e'(alt_sel);
    assign sel_pair = (which == PAIR_ALT) ? alt_q : pri_q;

endmodule

// File: rtl/hsync_match.sv
module hsync_match
    import hsync_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] hcount,
    input  logic [CNT_W-1:0] start,
    input  logic [END_W-1:0] stop,
    output logic             sync_raw
);

    logic hit_start;
    logic hit_stop;

    assign hit_start = (hcount == start);
    assign hit_stop  = low_match(hcount, stop);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_raw <= 1'b0;
        end else if (en) begin
            if (hit_start)
                sync_raw <= 1'b1;
            else if (hit_stop)
                sync_raw <= 1'b0;
        end
    end

endmodule

// File: rtl/hsync_delay.sv
module hsync_delay
    import hsync_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             din,
    input  logic [DLY_W-1:0] sel,
    output logic [DEPTH-1:0] pipe,
    output logic             dout
);

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_stage
            logic prev;
            if (g == 0) begin : g_head
                assign prev = din;
            end else begin : g_tail
                assign prev = pipe[g-1];
            end
            always_ff @(posedge clk) begin
                if (rst)
                    pipe[g] <= 1'b0;
                else if (en)
                    pipe[g] <= prev;
            end
        end
    endgenerate

    always_comb begin
        dout = din;
        for (int k = 1; k <= DEPTH; k++) begin
            if (int'(sel) == k)
                dout = pipe[k-1];
        end
    end

endmodule

// File: rtl/hsync_gen.sv
module hsync_gen
    import hsync_pkg::*;
#(
    parameter int DLY_DEPTH = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cclk_en,
    input  logic [CNT_W-1:0]  hcount,
    input  logic              alt_sel,
    input  logic              reg_we,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              hsync,
    output logic              blank_end_b5
);

    pair_t                sel_pair;
    logic                 sync_raw;
    logic [DLY_DEPTH-1:0] dly_pipe;

    hsync_regfile u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (reg_we),
        .idx      (reg_idx),
        .wdata    (reg_wdata),
        .alt_sel  (alt_sel),
        .rdata    (reg_rdata),
        .sel_pair (sel_pair)
    );

    hsync_match u_match (
        .clk      (clk),
        .rst      (rst),
        .en       (cclk_en),
        .hcount   (hcount),
        .start    (sel_pair.start),
        .stop     (sel_pair.fin.stop),
        .sync_raw (sync_raw)
    );

    hsync_delay #(.DEPTH(DLY_DEPTH)) u_dly (
        .clk  (clk),
        .rst  (rst),
        .en   (cclk_en),
        .din  (sync_raw),
        .sel  (sel_pair.fin.dly),
        .pipe (dly_pipe),
        .dout (hsync)
    );

    assign blank_end_b5 = sel_pair.fin.blank5;

endmodule

// File: rtl/hsync_gen_chk.sv
module hsync_gen_chk #(
    parameter int DEPTH = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic [7:0]       hcount,
    input logic [7:0]       start_q,
    input logic [4:0]       stop_q,
    input logic             sync_raw,
    input logic [DEPTH-1:0] pipe,
    input logic             hsync
);

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!hsync && !sync_raw && pipe == '0));

    a_r4_start_sets: assert property (@(posedge clk) disable iff (rst)
        (en && hcount == start_q) |=> sync_raw);

    a_r5_end_clears: assert property (@(posedge clk) disable iff (rst)
        (en && hcount != start_q && hcount[4:0] == stop_q) |=> !sync_raw);

    a_r6_start_wins: assert property (@(posedge clk) disable iff (rst)
        (en && hcount == start_q && hcount[4:0] == stop_q) |=> sync_raw);

    a_r7_pipe_head: assert property (@(posedge clk) disable iff (rst)
        en |=> (pipe[0] == $past(sync_raw)));

    a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(sync_raw) && $stable(pipe)));

endmodule

bind hsync_gen hsync_gen_chk #(.DEPTH(DLY_DEPTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (cclk_en),
    .hcount   (hcount),
    .start_q  (sel_pair.start),
    .stop_q   (sel_pair.fin.stop),
    .sync_raw (sync_raw),
    .pipe     (dly_pipe),
    .hsync    (hsync)
);

// File: tb/sim_hsync_gen.sv
module sim_hsync_gen;

    localparam int HT = 100;

    logic       clk = 1'b0;
    logic       rst;
    logic       cclk_en;
    logic [7:0] hcount;
    logic       alt_sel;
    logic       reg_we;
    logic [7:0] reg_idx;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       hsync;
    logic       blank_end_b5;

    int errors = 0;
    int checks = 0;
    int hc = 0;
    logic alt_b = 1'b0;

    // bench model state
    logic [7:0] m_ps = 0, m_pe = 0, m_as = 0, m_ae = 0;
    logic       m_raw = 0;
    logic [2:0] m_p = 0;

    always #4 clk = ~clk;

    hsync_gen u0 (
        .clk(clk), .rst(rst), .cclk_en(cclk_en), .hcount(hcount),
        .alt_sel(alt_sel), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .hsync(hsync), .blank_end_b5(blank_end_b5)
    );

    function automatic logic [7:0] sel_start();
        return alt_b ? m_as : m_ps;
    endfunction

    function automatic logic [7:0] sel_end();
        return alt_b ? m_ae : m_pe;
    endfunction

    function automatic logic exp_hsync();
        int d;
        d = int'(sel_end() >> 5) & 3;
        return (d == 0) ? m_raw : m_p[d-1];
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] idx);
        case (idx)
            8'h04:   return m_ps;
            8'h05:   return m_pe;
            8'h14:   return m_as;
            8'h15:   return m_ae;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one clock: inputs at falling edge, model at rising edge, check at next falling edge
    task automatic cyc(input logic en, input logic we, input logic [7:0] idx,
                       input logic [7:0] wd, input string tag);
        logic [7:0] s, e;
        cclk_en = en; reg_we = we; reg_idx = idx; reg_wdata = wd;
        hcount = 8'(hc); alt_sel = alt_b;
        @(posedge clk);
        s = sel_start(); e = sel_end();
        if (en) begin
            m_p = {m_p[1:0], m_raw};
            if (8'(hc) == s) m_raw = 1'b1;
            else if (8'(hc) % 32 == {3'b0, e[4:0]}) m_raw = 1'b0;
            hc = (hc + 1) % HT;
        end
        if (we) begin
            case (idx)
                8'h04: m_ps = wd;
                8'h05: m_pe = wd;
                8'h14: m_as = wd;
                8'h15: m_ae = wd;
                default: ;
            endcase
        end
        @(negedge clk);
        check({tag, " hsync"}, {7'b0, hsync}, {7'b0, exp_hsync()});
        check("R10 blank_end_b5", {7'b0, blank_end_b5}, {7'b0, sel_end()[7]});
        check("R2 R3 readback", reg_rdata, exp_read(idx));
    endtask

    task automatic wr(input logic [7:0] idx, input logic [7:0] v);
        cyc(1'b0, 1'b1, idx, v, "R2 write");
    endtask

    // run one full line with enable high; report width and first high position
    task automatic line(input string tag, output int width, output int first);
        width = 0; first = -1;
        for (int i = 0; i < HT; i++) begin
            cyc(1'b1, 1'b0, 8'h00, 8'h00, tag);
            if (hsync) begin
                width++;
                if (first < 0) first = hc;
            end
        end
    endtask

    task automatic program_pair(input logic alt, input int s, input int n, input int d, input logic b5);
        logic [7:0] e;
        e = {b5, 2'(d), 5'((s + n) % 32)};
        wr(alt ? 8'h14 : 8'h04, 8'(s));
        wr(alt ? 8'h15 : 8'h05, e);
    endtask

    task automatic width_test(input string tag, input logic alt, input int s, input int n, input int d);
        int w, f;
        program_pair(alt, s, n, d, 1'b0);
        alt_b = alt;
        hc = 0;
        line(tag, w, f);
        line(tag, w, f);
        check({tag, " width"}, 8'(w), 8'(n));
        check({tag, " first"}, 8'(f), 8'(s + 1 + d));
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int w, f;
        logic [7:0] ri, rv;
        void'($urandom(32'd1234));
        rst = 1'b1; cclk_en = 0; reg_we = 0; reg_idx = 0; reg_wdata = 0;
        hcount = 0; alt_sel = 0;
        repeat (3) @(negedge clk);
        // R1: reset state, checked while reset is still applied
        check("R1 hsync", {7'b0, hsync}, 8'h00);
        check("R1 blank", {7'b0, blank_end_b5}, 8'h00);
        foreach (ri[k]) begin end
        reg_idx = 8'h04; #1 check("R1 reg04", reg_rdata, 8'h00);
        reg_idx = 8'h05; #1 check("R1 reg05", reg_rdata, 8'h00);
        reg_idx = 8'h14; #1 check("R1 reg14", reg_rdata, 8'h00);
        reg_idx = 8'h15; #1 check("R1 reg15", reg_rdata, 8'h00);
        @(negedge clk);
        rst = 1'b0;

        // R2 write/readback, R3 unimplemented index
        wr(8'h04, 8'hA5); wr(8'h05, 8'h3C); wr(8'h14, 8'h5A); wr(8'h15, 8'hC3);
        wr(8'h06, 8'hFF);
        cyc(1'b0, 1'b0, 8'h06, 8'h00, "R3 unimpl");
        check("R3 unimplemented read", reg_rdata, 8'h00);
        cyc(1'b0, 1'b0, 8'h04, 8'h00, "R3 no side effect");
        check("R3 reg04 intact", reg_rdata, 8'hA5);

        // R4 R5 widths, including the 5-bit wrap and the full 32
        width_test("R5 N=1", 1'b0, 10, 1, 0);
        width_test("R5 wrap N=25", 1'b0, 20, 25, 0);
        width_test("R6 N=32 start wins", 1'b0, 40, 32, 0);
        width_test("R4 N=7", 1'b0, 3, 7, 0);
        // R7 delays
        for (int d = 0; d < 4; d++) width_test("R7 delay", 1'b0, 50, 4, d);
        // R9 alternate pair
        width_test("R9 alt pair", 1'b1, 30, 9, 2);
        program_pair(1'b1, 30, 9, 2, 1'b1);
        check("R10 alt blank bit", {7'b0, blank_end_b5}, 8'h01);
        alt_b = 1'b0;
        cyc(1'b0, 1'b0, 8'h00, 8'h00, "R9 back to primary");

        // R8: enable low while hcount sits on the start value
        program_pair(1'b0, 60, 5, 0, 1'b0);
        hc = 60;
        for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0, 8'h00, 8'h00, "R8 idle");
        check("R8 no start while idle", {7'b0, hsync}, 8'h00);

        // R11: write a new start equal to hcount during an enabled cycle
        program_pair(1'b0, 90, 5, 0, 1'b0);
        hc = 70;
        cyc(1'b1, 1'b1, 8'h04, 8'd70, "R11 same-cycle write");
        check("R11 old start used", {7'b0, hsync}, 8'h00);
        hc = 70;
        cyc(1'b1, 1'b0, 8'h00, 8'h00, "R11 next enable");
        check("R11 new start active", {7'b0, hsync}, 8'h01);

        // constrained random: enable ~75%, occasional writes and pair switches
        hc = 0;
        for (int i = 0; i < 4000; i++) begin
            logic en, we;
            en = ($urandom % 4) != 0;
            we = ($urandom % 60) == 0;
            case ($urandom % 5)
                0: ri = 8'h04; 1: ri = 8'h05; 2: ri = 8'h14; 3: ri = 8'h15;
                default: ri = 8'($urandom);
            endcase
            rv = (ri == 8'h04 || ri == 8'h14) ? 8'($urandom % HT) : 8'($urandom);
            if (($urandom % 300) == 0) alt_b = ~alt_b;
            cyc(en, we, ri, rv, "R4 R5 R7 R9 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule